// File: doc/BRIEF.md
# Multi-port MDIO management slave

This block is the serial management target of a multi-port physical-layer device. It runs on the management clock, samples the serial data line on each rising edge, and decodes clause-22 style management frames. One instance answers on a contiguous window of PHY addresses, one address per port, so a device with six ports needs only one serial engine. All other addresses are ignored, and the line is left released.

A write frame ends with a one-cycle write strobe that carries the port index, the register number and the 16-bit word, for the register file next to it. A read frame raises a one-cycle read strobe with the port index and register number during the first turnaround bit. The register file answers with a combinational word. The slave latches that word at the end of the strobe cycle, so clear-on-read status bits can clear on that same edge. It then drives a zero turnaround bit and the sixteen data bits, most significant first, and releases the line.

Frame hunting needs at least `PRE_LEN` consecutive ones before the start pattern. A short preamble, a bad start pattern or an unknown opcode sends the slave back to hunting.

Top module: `mdio_multiport_slave`

## Requirements
- R1: After reset `mdio_oe`, `rd_stb` and `wr_stb` are low.
- R2: A frame is accepted only after at least 32 consecutive ones on `mdio_i`, followed by start bits 0,1. With the write opcode 0,1, two turnaround bits and sixteen data bits D15 first, `wr_stb` is high for exactly the one cycle after the edge that samples D0. In that cycle `wr_data`, `acc_port` and `acc_reg` are valid.
- R3: With the read opcode 1,0, `rd_stb` is high for exactly the one cycle that follows the edge sampling the last register-address bit R0. In that cycle `mdio_oe` is low and `acc_port`/`acc_reg` name the target.
- R4: In a read, the cycle after the read strobe drives `mdio_oe`=1, `mdio_o`=0. The next sixteen cycles drive `rd_data`, as sampled at the end of the strobe cycle, from bit 15 down to bit 0.
- R5: The cycle after D0 of a read reply, `mdio_oe` returns low.
- R6: A frame whose 5-bit PHY address is outside PHY_BASE..PHY_BASE+NPORTS-1 (default 8..13) gives no strobe and leaves `mdio_oe` low throughout.
- R7: A preamble of only 31 ones before the start bits gives no response to that frame.
- R8: A start field of 0,0 sends the slave back to hunting, and the frame gets no response.
- R9: Opcodes 0,0 and 1,1 give no strobe and no line drive.
- R10: Every address in the window is served, and `acc_port` equals the PHY address minus PHY_BASE. The PHY address is sent A4 first, then the register address R4 first.
- R11: `mdio_oe` is high only during the 17-cycle read reply that follows a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mdc | input | 1 | Management clock; every register updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_i | input | 1 | Serial data line as seen at the pad |
| mdio_o | output | 1 | Serial data to drive when enabled |
| mdio_oe | output | 1 | Pad drive enable |
| acc_port | output | PORT_W (3) | Port index of the current access |
| acc_reg | output | ADDR_W (5) | Register number of the current access |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_data | output | DATA_W (16) | Written word, valid with `wr_stb` |
| rd_stb | output | 1 | One-cycle read strobe; the register file may clear on-read bits |
| rd_data | input | DATA_W (16) | Register file read word, sampled at the end of the `rd_stb` cycle |

## Verification
The checker watches, on every cycle, that each strobe lasts one cycle and that the two never coincide. It also checks that the line is released while the read strobe is high, that the turnaround zero follows the strobe, that the drive enable rises only after a read strobe and never stays up longer than the reply, and that the port index stays inside the window. Only the bench's frames can show what the checker cannot: the decoding of each address and register field, the bit order of returned and written words, the exact cycle of each strobe, and that rejected frames (short preamble, bad start, unknown opcode, foreign address) leave no trace. The bench sweeps all 32 PHY addresses in both directions against arithmetic expectations.

// File: rtl/mdio_mps_pkg.sv
package mdio_mps_pkg;

   typedef enum logic [2:0] {
      S_HUNT,
      S_START,
      S_HDR,
      S_TA1,
      S_TA2,
      S_DATA
   } mps_state_t;

   localparam logic [1:0] OP_WRITE = 2'b01;
   localparam logic [1:0] OP_READ  = 2'b10;

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det #(
   parameter int PRE_LEN = 32
) (
   input  logic mdc,
   input  logic rst_n,
   input  logic hunt,
   input  logic bit_i,
   output logic pre_ok
);
   localparam int CW = $clog2(PRE_LEN + 1);
   localparam logic [CW-1:0] SAT = CW'(PRE_LEN);

   logic [CW-1:0] ones_q;

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (!hunt || !bit_i) begin
         ones_q <= '0;
      end else if (ones_q != SAT) begin
         ones_q <= ones_q + 1'b1;
      end
   end

   assign pre_ok = (ones_q == SAT);

endmodule

// File: rtl/mdio_port_match.sv
module mdio_port_match #(
   parameter int ADDR_W    = 5,
   parameter int NPORTS    = 6,
   parameter int PHY_BASE  = 8,
   parameter int PORT_W    = 3
) (
   input  logic [ADDR_W-1:0] phy,
   output logic              hit,
   output logic [PORT_W-1:0] port
);
   localparam bit POW2    = (NPORTS >= 2) && ((NPORTS & (NPORTS - 1)) == 0);
   localparam bit ALIGNED = POW2 && ((PHY_BASE % (POW2 ? NPORTS : 1)) == 0);

   generate
      if (ALIGNED) begin : g_aligned
         localparam int HI_W = ADDR_W - PORT_W;
         localparam logic [HI_W-1:0] BASE_HI = HI_W'(PHY_BASE >> PORT_W);
         assign hit  = (phy[ADDR_W-1:PORT_W] == BASE_HI);
         assign port = phy[PORT_W-1:0];
      end else begin : g_subtract
         logic [ADDR_W:0] diff;
         assign diff = {1'b0, phy} - (ADDR_W+1)'(PHY_BASE);
         assign hit  = !diff[ADDR_W] && (diff < (ADDR_W+1)'(NPORTS));
         assign port = diff[PORT_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/mdio_rd_shift.sv
module mdio_rd_shift #(
   parameter int DATA_W = 16
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic              load,
   input  logic              step,
   input  logic              done,
   input  logic [DATA_W-1:0] din,
   output logic              pad_o,
   output logic              pad_oe
);
   logic [DATA_W-1:0] sh_q;

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '0;
         pad_o  <= 1'b0;
         pad_oe <= 1'b0;
      end else if (load) begin
         sh_q   <= din;
         pad_o  <= 1'b0;
         pad_oe <= 1'b1;
      end else if (step) begin
         pad_o  <= sh_q[DATA_W-1];
         sh_q   <= {sh_q[DATA_W-2:0], 1'b0};
      end else if (done) begin
         pad_o  <= 1'b0;
         pad_oe <= 1'b0;
      end
   end

endmodule

// File: rtl/mdio_multiport_slave.sv
module mdio_multiport_slave
   import mdio_mps_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 5,
   parameter int NPORTS   = 6,
   parameter int PHY_BASE = 8,
   parameter int PRE_LEN  = 32,
   parameter int PORT_W   = (NPORTS > 1) ? $clog2(NPORTS) : 1
) (
   input  logic              mdc,
   input  logic              rst_n,
   input  logic              mdio_i,
   output logic              mdio_o,
   output logic              mdio_oe,
   output logic [PORT_W-1:0] acc_port,
   output logic [ADDR_W-1:0] acc_reg,
   output logic              wr_stb,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_stb,
   input  logic [DATA_W-1:0] rd_data
);
   localparam int HDR_LEN = 2 + 2 * ADDR_W;
   localparam int CNT_MAX = (DATA_W > HDR_LEN) ? DATA_W : HDR_LEN;
   localparam int CNT_W   = $clog2(CNT_MAX);
   localparam logic [CNT_W-1:0] HDR_LAST  = CNT_W'(HDR_LEN - 1);
   localparam logic [CNT_W-1:0] DATA_LAST = CNT_W'(DATA_W - 1);

   initial begin
      if (NPORTS < 1 || PHY_BASE < 0 || PHY_BASE + NPORTS > (1 << ADDR_W))
         $fatal(1, "port window does not fit the address field");
      if (DATA_W < 2 || PRE_LEN < 1)
         $fatal(1, "data width or preamble length out of range");
      if ((1 << PORT_W) < NPORTS)
         $fatal(1, "PORT_W too narrow for NPORTS");
   end

   mps_state_t        state_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [HDR_LEN-2:0] hdr_q;
   logic [HDR_LEN-1:0] hdr_nxt;
   logic [DATA_W-2:0] wsh_q;
   logic              is_rd_q;
   logic              hit_q;
   logic              pre_ok;
   logic              m_hit;
   logic [PORT_W-1:0] m_port;
   logic [1:0]        op_nxt;
   logic              op_ok;
   logic              rd_act;
   logic              sh_step;
   logic              sh_done;

   assign hdr_nxt = {hdr_q, mdio_i};
   assign op_nxt  = hdr_nxt[HDR_LEN-1 -: 2];
   assign op_ok   = (op_nxt == OP_WRITE) || (op_nxt == OP_READ);
   assign rd_act  = is_rd_q && hit_q;

   mdio_pre_det #(.PRE_LEN(PRE_LEN)) i_pre (
      .mdc   (mdc),
      .rst_n (rst_n),
      .hunt  (state_q == S_HUNT),
      .bit_i (mdio_i),
      .pre_ok(pre_ok)
   );

   mdio_port_match #(
      .ADDR_W  (ADDR_W),
      .NPORTS  (NPORTS),
      .PHY_BASE(PHY_BASE),
      .PORT_W  (PORT_W)
   ) i_match (
      .phy (hdr_nxt[2*ADDR_W-1 -: ADDR_W]),
      .hit (m_hit),
      .port(m_port)
   );

   assign rd_stb  = (state_q == S_TA1) && rd_act;
   assign sh_step = rd_act && ((state_q == S_TA2) ||
                               ((state_q == S_DATA) && (cnt_q != DATA_LAST)));
   assign sh_done = rd_act && (state_q == S_DATA) && (cnt_q == DATA_LAST);

   mdio_rd_shift #(.DATA_W(DATA_W)) i_shift (
      .mdc   (mdc),
      .rst_n (rst_n),
      .load  (rd_stb),
      .step  (sh_step),
      .done  (sh_done),
      .din   (rd_data),
      .pad_o (mdio_o),
      .pad_oe(mdio_oe)
   );

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= S_HUNT;
         cnt_q    <= '0;
         hdr_q    <= '0;
         wsh_q    <= '0;
         is_rd_q  <= 1'b0;
         hit_q    <= 1'b0;
         acc_port <= '0;
         acc_reg  <= '0;
         wr_stb   <= 1'b0;
         wr_data  <= '0;
      end else begin
         wr_stb <= 1'b0;
         unique case (state_q)
            S_HUNT: begin
               if (!mdio_i && pre_ok) state_q <= S_START;
            end
            S_START: begin
               cnt_q   <= '0;
               state_q <= mdio_i ? S_HDR : S_HUNT;
            end
            S_HDR: begin
               hdr_q <= hdr_nxt[HDR_LEN-2:0];
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == HDR_LAST) begin
                  if (op_ok) begin
                     state_q <= S_TA1;
                     is_rd_q <= (op_nxt == OP_READ);
                     hit_q   <= m_hit;
                     if (m_hit) begin
                        acc_port <= m_port;
                        acc_reg  <= hdr_nxt[ADDR_W-1:0];
                     end
                  end else begin
                     state_q <= S_HUNT;
                     hit_q   <= 1'b0;
                  end
               end
            end
            S_TA1: begin
               state_q <= S_TA2;
            end
            S_TA2: begin
               cnt_q   <= '0;
               state_q <= S_DATA;
            end
            S_DATA: begin
               wsh_q <= {wsh_q[DATA_W-3:0], mdio_i};
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == DATA_LAST) begin
                  state_q <= S_HUNT;
                  if (hit_q && !is_rd_q) begin
                     wr_stb  <= 1'b1;
                     wr_data <= {wsh_q, mdio_i};
                  end
                  hit_q <= 1'b0;
               end
            end
            default: state_q <= S_HUNT;
         endcase
      end
   end

endmodule

// File: rtl/mdio_mps_chk.sv
module mdio_mps_chk #(
   parameter int DATA_W = 16,
   parameter int NPORTS = 6,
   parameter int PORT_W = 3
) (
   input logic              mdc,
   input logic              rst_n,
   input logic              mdio_o,
   input logic              mdio_oe,
   input logic              rd_stb,
   input logic              wr_stb,
   input logic [PORT_W-1:0] acc_port
);
   localparam int RUN_W = $clog2(DATA_W + 3);
   logic [RUN_W-1:0] oe_run;

   always_ff @(posedge mdc or negedge rst_n) begin
      if (!rst_n)        oe_run <= '0;
      else if (mdio_oe)  oe_run <= oe_run + 1'b1;
      else               oe_run <= '0;
   end

   // R3: read strobe lasts a single cycle
   a_r3_rd_stb_single: assert property (@(posedge mdc) disable iff (!rst_n)
      rd_stb |=> !rd_stb);

   // R2: write strobe lasts a single cycle
   a_r2_wr_stb_single: assert property (@(posedge mdc) disable iff (!rst_n)
      wr_stb |=> !wr_stb);

   a_r2_no_both_stb: assert property (@(posedge mdc) disable iff (!rst_n)
      !(rd_stb && wr_stb));

   // R3: line released during the first turnaround bit
   a_r3_released_on_stb: assert property (@(posedge mdc) disable iff (!rst_n)
      rd_stb |-> !mdio_oe);

   // R4: second turnaround bit is a driven zero
   a_r4_ta_zero: assert property (@(posedge mdc) disable iff (!rst_n)
      rd_stb |=> (mdio_oe && !mdio_o));

   // R11: drive only begins right after a read strobe
   a_r11_oe_origin: assert property (@(posedge mdc) disable iff (!rst_n)
      $rose(mdio_oe) |-> $past(rd_stb));

   // R5: drive never outlasts turnaround zero plus data
   a_r5_oe_window: assert property (@(posedge mdc) disable iff (!rst_n)
      mdio_oe |-> (oe_run < RUN_W'(DATA_W + 1)));

   // R10: reported port stays inside the window
   a_r10_port_range: assert property (@(posedge mdc) disable iff (!rst_n)
      (rd_stb || wr_stb) |-> (int'(acc_port) < NPORTS));

endmodule

bind mdio_multiport_slave mdio_mps_chk #(
   .DATA_W(DATA_W),
   .NPORTS(NPORTS),
   .PORT_W(PORT_W)
) i_mdio_mps_chk (
   .mdc     (mdc),
   .rst_n   (rst_n),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe),
   .rd_stb  (rd_stb),
   .wr_stb  (wr_stb),
   .acc_port(acc_port)
);

// File: tb/test_mdio_multiport_slave.sv
module test_mdio_multiport_slave;
   localparam int BASE = 8;
   localparam int NP   = 6;

   logic        mdc = 1'b0;
   logic        rst_n = 1'b0;
   logic        mdio_i = 1'b1;
   logic        mdio_o, mdio_oe, wr_stb, rd_stb;
   logic [2:0]  acc_port;
   logic [4:0]  acc_reg;
   logic [15:0] wr_data, rd_data;

   int checks = 0;
   int fails  = 0;

   always #5 mdc = ~mdc;

   function automatic logic [15:0] rmodel(input logic [2:0] p, input logic [4:0] r);
      return {r, p, 8'hC3 ^ {p, r}};
   endfunction

   assign rd_data = rmodel(acc_port, acc_reg);

   mdio_multiport_slave i_mdio_multiport_slave (
      .mdc(mdc), .rst_n(rst_n), .mdio_i(mdio_i), .mdio_o(mdio_o),
      .mdio_oe(mdio_oe), .acc_port(acc_port), .acc_reg(acc_reg),
      .wr_stb(wr_stb), .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
      end
   endtask

   // bit 0 is a leading zero that clears any partial preamble
   task automatic run_frame(input int pre, input logic [1:0] st, input logic [1:0] op,
                            input int phy, input logic [4:0] rg, input logic [15:0] dat,
                            input string tag);
      logic bv [0:127];
      int n, h, idx;
      bit valid, rd, wr;
      logic [2:0] ep;
      logic [15:0] rexp;
      idx = 0;
      bv[idx++] = 1'b0;
      for (int i = 0; i < pre; i++) bv[idx++] = 1'b1;
      bv[idx++] = st[1]; bv[idx++] = st[0];
      bv[idx++] = op[1]; bv[idx++] = op[0];
      for (int i = 4; i >= 0; i--) bv[idx++] = 1'(phy >> i);
      for (int i = 4; i >= 0; i--) bv[idx++] = rg[i];
      bv[idx++] = 1'b1; bv[idx++] = 1'b0;
      for (int i = 15; i >= 0; i--) bv[idx++] = dat[i];
      n = idx;
      h = pre + 14;
      valid = (pre >= 32) && (st == 2'b01) && (op == 2'b01 || op == 2'b10) &&
              (phy >= BASE) && (phy < BASE + NP);
      rd = valid && (op == 2'b10);
      wr = valid && (op == 2'b01);
      ep = 3'(phy - BASE);
      rexp = rmodel(ep, rg);
      for (int k = 0; k <= n + 2; k++) begin
         @(negedge mdc);
         if (k >= 1) begin
            logic eoe;
            eoe = rd && (k >= h + 2) && (k <= h + 18);
            chk({tag, " R11 oe"}, 32'(mdio_oe), 32'(eoe));
            chk({tag, " R3 rd_stb"}, 32'(rd_stb), 32'(rd && k == h + 1));
            chk({tag, " R2 wr_stb"}, 32'(wr_stb), 32'(wr && k == h + 19));
            if (rd && k == h + 1) begin
               chk({tag, " R10 rd port"}, 32'(acc_port), 32'(ep));
               chk({tag, " R3 rd reg"}, 32'(acc_reg), 32'(rg));
            end
            if (rd && k == h + 2) chk({tag, " R4 ta zero"}, 32'(mdio_o), 32'(0));
            if (rd && k >= h + 3 && k <= h + 18)
               chk({tag, " R4 data bit"}, 32'(mdio_o), 32'(rexp[15 - (k - h - 3)]));
            if (rd && k == h + 19) chk({tag, " R5 release"}, 32'(mdio_oe), 32'(0));
            if (wr && k == h + 19) begin
               chk({tag, " R2 wr_data"}, 32'(wr_data), 32'(dat));
               chk({tag, " R10 wr port"}, 32'(acc_port), 32'(ep));
               chk({tag, " R2 wr reg"}, 32'(acc_reg), 32'(rg));
            end
         end
         mdio_i = (k < n) ? bv[k] : 1'b1;
      end
   endtask

   task automatic summary;
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   initial begin
      repeat (150000) @(posedge mdc);
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge mdc);
      chk("R1 oe", 32'(mdio_oe), 0);
      chk("R1 rd_stb", 32'(rd_stb), 0);
      chk("R1 wr_stb", 32'(wr_stb), 0);
      rst_n = 1'b1;
      // R6 R10: full address sweep, both directions
      for (int p = 0; p < 32; p++) begin
         for (int r = 0; r < 3; r++) begin
            logic [4:0] rg;
            rg = 5'((r * 17 + p) % 32);
            run_frame(32, 2'b01, 2'b01, p, rg, 16'((p * 16'h1357) ^ (r * 16'h8421)), "R6 sweep wr");
            run_frame(32, 2'b01, 2'b10, p, rg, 16'h0, "R6 sweep rd");
         end
      end
      // R7: short preamble, then long preamble
      run_frame(31, 2'b01, 2'b10, BASE, 5'd3, 16'h0, "R7 short rd");
      run_frame(31, 2'b01, 2'b01, BASE + 1, 5'd4, 16'hBEEF, "R7 short wr");
      run_frame(40, 2'b01, 2'b01, BASE + 5, 5'd31, 16'h8001, "R2 long pre");
      // R8: bad start field
      run_frame(32, 2'b00, 2'b10, BASE + 2, 5'd7, 16'h0, "R8 bad st");
      run_frame(32, 2'b00, 2'b01, BASE + 2, 5'd7, 16'hFFFF, "R8 bad st wr");
      // R9: undefined opcodes
      run_frame(32, 2'b01, 2'b00, BASE + 3, 5'd9, 16'h1234, "R9 op00");
      run_frame(32, 2'b01, 2'b11, BASE + 4, 5'd10, 16'h4321, "R9 op11");
      run_frame(32, 2'b01, 2'b10, BASE + 4, 5'd0, 16'h0, "R5 recover rd");
      summary();
      $finish;
   end

endmodule